// File: doc/BRIEF.md
# Serial Instruction Injection Port

This block is the device end of a two-wire programming link. An external host drives a serial clock and a data line that can turn around. The port recovers control codes and instruction words from that line and hands each instruction word to the CPU on a parallel output. On request, it sends a 16-bit visibility word from the CPU back to the host over the same data line.

The port is armed only while the high-voltage reset qualifier is asserted. Right after it is armed, the first frame is treated as an execute frame without a code: it has a few padding clocks, which are discarded, and then 24 instruction bits. After that, every frame starts with a 4-bit control code.

- Code 0 loads a 24-bit instruction word.
- Code 1 turns the data line around and shifts the visibility word out.
- Any other code is dropped.

The serial clock and data are oversampled by the system clock through a two-register synchronizer. The host must therefore hold each serial clock level for at least four system clocks.

The instruction output is a valid/ready stream, but the serial host cannot be held back. The rules for the stream are:

- A word stays offered until `insn_ready` is seen high on a clock edge.
- A word that completes while the previous one is still pending replaces it.
- If a word completes on the same edge that accepts the previous one, `insn_valid` stays high with the new word.

Top module: `serial_inject_port`

## Requirements
- R1: `prog_active` equals `hv_reset` delayed by one clock. While `hv_reset` is low, `insn_valid` and `ser_doe` are low and the port is idle.
- R2: Serial inputs are synchronized by two registers. A `ser_clk` level first captured at clock edge m takes effect in the registers updated at edge m+2. The `ser_din` value used is the one captured at edge m.
- R3: The first frame after arming consists of 5 `ser_clk` falling edges whose data is ignored, followed by 24 instruction bits. That frame has no control code.
- R4: Every later frame starts with a 4-bit code sampled on `ser_clk` falling edges, least significant bit first. Code 4'b0000 is followed by 24 bits, least significant bit first, that form the word on `insn_data`.
- R5: `insn_valid` rises on the edge that captures the 24th bit and holds until an edge with `insn_ready` high. A completion on the accepting edge keeps it high with the new word, and a completion while pending overwrites `insn_data`.
- R6: Code 4'b0001 captures `vis_word` on the falling edge that completes the code. Its 16 bits are then driven on `ser_dout`, least significant bit first, one per `ser_clk` rising edge.
- R7: `ser_doe` rises with the first rising edge of the read-out and falls on its 16th falling edge, before the next code's first bit is sampled.
- R8: Any code other than 0 or 1 yields no word and no output enable, and the next frame is decoded as a new code.
- R9: `ser_clk` activity while `hv_reset` is low has no effect. After arming, the forced frame of R3 still applies.
- R10: While armed, `ser_dout` changes only as the result of a `ser_clk` rising edge.
- R11: After `rst_n` all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_reset | input | 1 | High-voltage reset qualifier, arms the port |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host |
| ser_doe | output | 1 | Output enable for the serial data line |
| vis_word | input | 16 | Visibility register value from the CPU |
| insn_data | output | 24 | Last complete instruction word |
| insn_valid | output | 1 | Instruction word offered to the CPU |
| insn_ready | input | 1 | CPU accepts the offered word |
| prog_active | output | 1 | Programming mode armed |

## Verification
Two events can fall on the same clock edge: the completion of a new instruction word and the CPU's acceptance of the pending one. The bench holds `insn_ready` low so that a word stays pending, then shifts in a second word. It raises `insn_ready` exactly on the edge that the synchronizer latency makes the capture edge for the 24th bit. The result is correct if `insn_valid` never drops and `insn_data` shows the second word. A behavioural model is compared on every clock, so the same edge is also judged against the one-edge-late and one-edge-early alternatives.

// File: rtl/sip_pkg.sv
package sip_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_FORCE,
    ST_CODE,
    ST_EXEC,
    ST_READ
  } sip_state_e;
endpackage

// File: rtl/sip_edge_sync.sv
module sip_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic sdata_in,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic sdata_sync
);
  // one extra stage on the clock line gives the previous level for edge detection
  logic [STAGES:0]   clk_pipe;
  logic [STAGES-1:0] dat_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-1:0], sclk_in};
      dat_pipe <= {dat_pipe[STAGES-2:0], sdata_in};
    end
  end

  assign sclk_fall  = clk_pipe[STAGES] & ~clk_pipe[STAGES-1];
  assign sclk_rise  = ~clk_pipe[STAGES] & clk_pipe[STAGES-1];
  assign sdata_sync = dat_pipe[STAGES-1];
endmodule

// File: rtl/sip_tx_shift.sv
module sip_tx_shift #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         release_oe,
  output logic         drv,
  output logic         oe
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      drv <= 1'b0;
      oe  <= 1'b0;
    end else if (clr) begin
      sr  <= '0;
      drv <= 1'b0;
      oe  <= 1'b0;
    end else begin
      if (load) begin
        sr <= load_val;
      end else if (shift) begin
        drv <= sr[0];
        sr  <= {1'b0, sr[W-1:1]};
        oe  <= 1'b1;
      end
      if (release_oe) oe <= 1'b0;
    end
  end
endmodule

// File: rtl/sip_rx_ctrl.sv
module sip_rx_ctrl
  import sip_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int INSTR_W    = 24,
  parameter int VIS_W      = 16,
  parameter int FORCE_CLKS = 5,
  parameter int CODE_EXEC  = 0,
  parameter int CODE_READ  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hv_reset,
  input  logic               prog_active,
  input  logic               s_fall,
  input  logic               s_rise,
  input  logic               s_bit,
  input  logic               insn_ready,
  output logic               tx_load,
  output logic               tx_shift,
  output logic               tx_release,
  output logic [INSTR_W-1:0] insn_data,
  output logic               insn_valid
);
  localparam int MAX_A = (INSTR_W > VIS_W) ? INSTR_W : VIS_W;
  localparam int MAX_B = (FORCE_CLKS > CODE_W) ? FORCE_CLKS : CODE_W;
  localparam int MAX_N = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_N);
  localparam logic [CNT_W-1:0] LAST_CODE  = CNT_W'(CODE_W - 1);
  localparam logic [CNT_W-1:0] LAST_INSTR = CNT_W'(INSTR_W - 1);
  localparam logic [CNT_W-1:0] LAST_VIS   = CNT_W'(VIS_W - 1);
  localparam logic [CNT_W-1:0] LAST_FORCE = CNT_W'(FORCE_CLKS - 1);

  sip_state_e           state;
  logic [CNT_W-1:0]     cnt;
  logic [CODE_W-2:0]    code_sr;
  logic [INSTR_W-2:0]   isr;
  logic [CODE_W-1:0]    code_full;
  logic [INSTR_W-1:0]   instr_full;
  logic                 armed;

  assign armed      = hv_reset && prog_active;
  assign code_full  = {s_bit, code_sr};
  assign instr_full = {s_bit, isr};

  assign tx_load    = armed && s_fall && (state == ST_CODE) && (cnt == LAST_CODE)
                      && (code_full == CODE_W'(CODE_READ));
  assign tx_shift   = armed && s_rise && (state == ST_READ);
  assign tx_release = armed && s_fall && (state == ST_READ) && (cnt == LAST_VIS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_OFF;
      cnt        <= '0;
      code_sr    <= '0;
      isr        <= '0;
      insn_data  <= '0;
      insn_valid <= 1'b0;
    end else begin
      if (insn_valid && insn_ready) insn_valid <= 1'b0;
      if (!hv_reset) begin
        state      <= ST_OFF;
        cnt        <= '0;
        insn_valid <= 1'b0;
      end else if (!prog_active) begin
        state <= ST_FORCE;
        cnt   <= '0;
      end else if (s_fall) begin
        case (state)
          ST_FORCE: begin
            if (cnt == LAST_FORCE) begin
              state <= ST_EXEC;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_CODE: begin
            code_sr <= code_full[CODE_W-1:1];
            if (cnt == LAST_CODE) begin
              cnt <= '0;
              if (code_full == CODE_W'(CODE_EXEC))      state <= ST_EXEC;
              else if (code_full == CODE_W'(CODE_READ)) state <= ST_READ;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_EXEC: begin
            isr <= instr_full[INSTR_W-1:1];
            if (cnt == LAST_INSTR) begin
              insn_data  <= instr_full;
              insn_valid <= 1'b1;
              state      <= ST_CODE;
              cnt        <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_READ: begin
            if (cnt == LAST_VIS) begin
              state <= ST_CODE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_inject_port.sv
module serial_inject_port #(
  parameter int CODE_W      = 4,
  parameter int INSTR_W     = 24,
  parameter int VIS_W       = 16,
  parameter int FORCE_CLKS  = 5,
  parameter int SYNC_STAGES = 2,
  parameter int CODE_EXEC   = 0,
  parameter int CODE_READ   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hv_reset,
  input  logic               ser_clk,
  input  logic               ser_din,
  output logic               ser_dout,
  output logic               ser_doe,
  input  logic [VIS_W-1:0]   vis_word,
  output logic [INSTR_W-1:0] insn_data,
  output logic               insn_valid,
  input  logic               insn_ready,
  output logic               prog_active
);
  logic s_rise, s_fall, s_bit;
  logic tx_load, tx_shift, tx_release;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prog_active <= 1'b0;
    else        prog_active <= hv_reset;
  end

  sip_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_in    (ser_clk),
    .sdata_in   (ser_din),
    .sclk_rise  (s_rise),
    .sclk_fall  (s_fall),
    .sdata_sync (s_bit)
  );

  sip_rx_ctrl #(
    .CODE_W     (CODE_W),
    .INSTR_W    (INSTR_W),
    .VIS_W      (VIS_W),
    .FORCE_CLKS (FORCE_CLKS),
    .CODE_EXEC  (CODE_EXEC),
    .CODE_READ  (CODE_READ)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .hv_reset    (hv_reset),
    .prog_active (prog_active),
    .s_fall      (s_fall),
    .s_rise      (s_rise),
    .s_bit       (s_bit),
    .insn_ready  (insn_ready),
    .tx_load     (tx_load),
    .tx_shift    (tx_shift),
    .tx_release  (tx_release),
    .insn_data   (insn_data),
    .insn_valid  (insn_valid)
  );

  sip_tx_shift #(.W(VIS_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (!hv_reset),
    .load       (tx_load),
    .load_val   (vis_word),
    .shift      (tx_shift),
    .release_oe (tx_release),
    .drv        (ser_dout),
    .oe         (ser_doe)
  );
endmodule

// File: rtl/sip_checker.sv
module sip_checker (
  input logic clk,
  input logic rst_n,
  input logic prog_active,
  input logic ser_doe,
  input logic ser_dout,
  input logic insn_valid,
  input logic insn_ready,
  input logic s_rise,
  input logic s_fall
);
  AST_DOE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_active |-> !ser_doe); // R1
  AST_VALID_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_active |-> !insn_valid); // R1
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !insn_ready && prog_active) |=> (insn_valid || !prog_active)); // R5
  AST_VALID_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(insn_valid) |-> $past(s_fall)); // R5
  AST_DOE_FROM_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_doe) |-> $past(s_rise)); // R7
  AST_DOE_DROP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ser_doe) && prog_active) |-> $past(s_fall)); // R7
  AST_DOUT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_active && !$stable(ser_dout)) |-> $past(s_rise)); // R10
endmodule

bind serial_inject_port sip_checker u_sip_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .prog_active (prog_active),
  .ser_doe     (ser_doe),
  .ser_dout    (ser_dout),
  .insn_valid  (insn_valid),
  .insn_ready  (insn_ready),
  .s_rise      (s_rise),
  .s_fall      (s_fall)
);

// File: tb/serial_inject_port_bench.sv
module serial_inject_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hv_reset = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        ser_dout, ser_doe;
  logic [15:0] vis_word = 16'h0;
  logic [23:0] insn_data;
  logic        insn_valid;
  logic        insn_ready = 1'b0;
  logic        prog_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_inject_port u_serial_inject_port (
    .clk(clk), .rst_n(rst_n), .hv_reset(hv_reset), .ser_clk(ser_clk),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_doe(ser_doe),
    .vis_word(vis_word), .insn_data(insn_data), .insn_valid(insn_valid),
    .insn_ready(insn_ready), .prog_active(prog_active)
  );

  // behavioural reference: 0 off, 1 padding, 2 code, 3 instruction, 4 read-out
  int          m_state, m_cnt;
  logic        m_mode, m_valid, m_oe, m_dout;
  logic [23:0] m_data, m_word;
  logic [3:0]  m_code;
  logic [15:0] m_tx;
  logic [3:0]  hc, hd;

  always @(posedge clk) begin
    logic fall, rise, b;
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_mode = 0; m_valid = 0; m_oe = 0; m_dout = 0;
      m_data = 0; m_word = 0; m_code = 0; m_tx = 0; hc = 0; hd = 0;
    end else begin
      fall = hc[2] & ~hc[1];
      rise = ~hc[2] & hc[1];
      b    = hd[1];
      if (m_valid && insn_ready) m_valid = 0;
      if (!hv_reset) begin
        m_mode = 0; m_state = 0; m_cnt = 0; m_valid = 0; m_oe = 0; m_dout = 0; m_tx = 0;
      end else if (!m_mode) begin
        m_mode = 1; m_state = 1; m_cnt = 0;
      end else begin
        case (m_state)
          1: if (fall) begin
               m_cnt++;
               if (m_cnt == 5) begin m_state = 3; m_cnt = 0; end
             end
          2: if (fall) begin
               m_code[m_cnt] = b; m_cnt++;
               if (m_cnt == 4) begin
                 m_cnt = 0;
                 if (m_code == 4'd0) m_state = 3;
                 else if (m_code == 4'd1) begin m_state = 4; m_tx = vis_word; end
               end
             end
          3: if (fall) begin
               m_word[m_cnt] = b; m_cnt++;
               if (m_cnt == 24) begin
                 m_data = m_word; m_valid = 1; m_state = 2; m_cnt = 0;
               end
             end
          4: begin
               if (rise) begin m_dout = m_tx[0]; m_tx = m_tx >> 1; m_oe = 1; end
               if (fall) begin
                 m_cnt++;
                 if (m_cnt == 16) begin m_oe = 0; m_state = 2; m_cnt = 0; end
               end
             end
          default: ;
        endcase
      end
      hc = {hc[2:0], ser_clk};
      hd = {hd[2:0], ser_din};
    end
  end

  // clock-by-clock comparison, away from the active edge (R2 timing)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (prog_active !== m_mode) begin
        errors++; $display("FAIL R1 prog_active act=%0b exp=%0b", prog_active, m_mode);
      end
      if (insn_valid !== m_valid) begin
        errors++; $display("FAIL R2 R5 insn_valid act=%0b exp=%0b", insn_valid, m_valid);
      end
      if (m_valid && insn_data !== m_data) begin
        errors++; $display("FAIL R4 insn_data act=%h exp=%h", insn_data, m_data);
      end
      if (ser_doe !== m_oe) begin
        errors++; $display("FAIL R7 ser_doe act=%0b exp=%0b", ser_doe, m_oe);
      end
      if (m_oe && ser_dout !== m_dout) begin
        errors++; $display("FAIL R6 R10 ser_dout act=%0b exp=%0b", ser_dout, m_dout);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    ser_din = b;
    ser_clk = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_code(input logic [3:0] c);
    for (int i = 0; i < 4; i++) bit_out(c[i]);
  endtask

  task automatic send_word(input logic [23:0] w);
    for (int i = 0; i < 24; i++) bit_out(w[i]);
  endtask

  task automatic send_pad();
    for (int i = 0; i < 5; i++) bit_out(1'b1);
  endtask

  task automatic read_vis(output logic [15:0] v);
    for (int i = 0; i < 16; i++) begin
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      v[i] = ser_dout;
      ser_clk = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic accept();
    insn_ready = 1'b1;
    @(negedge clk);
    insn_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (5) @(negedge clk);
    check(prog_active === 0 && insn_valid === 0 && ser_doe === 0 && insn_data === 0,
          "R11 reset outputs", {prog_active, insn_valid, ser_doe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: serial activity while disarmed
    send_word(24'hFFFFFF);
    check(insn_valid === 0 && ser_doe === 0 && prog_active === 0, "R9 disarmed activity",
          {insn_valid, ser_doe, prog_active}, 0);

    hv_reset = 1'b1;
    repeat (3) @(negedge clk);
    check(prog_active === 1, "R1 armed", prog_active, 1);

    // R3: forced first frame
    send_pad();
    check(insn_valid === 0, "R3 padding yields no word", insn_valid, 0);
    send_word(24'hA5C3F1);
    check(insn_valid === 1 && insn_data === 24'hA5C3F1, "R3 forced word", insn_data, 24'hA5C3F1);
    accept();
    check(insn_valid === 0, "R5 accepted", insn_valid, 0);

    // R4: execute frames with different patterns
    send_code(4'b0000); send_word(24'h123456);
    check(insn_valid === 1 && insn_data === 24'h123456, "R4 word", insn_data, 24'h123456);
    send_code(4'b0000); send_word(24'h800001);
    check(insn_valid === 1 && insn_data === 24'h800001, "R5 overwrite pending", insn_data, 24'h800001);
    accept();

    // R6 R7: read-out
    vis_word = 16'hBEEF;
    send_code(4'b0001);
    read_vis(v);
    check(v === 16'hBEEF, "R6 read-out", v, 16'hBEEF);
    repeat (3) @(negedge clk);
    check(ser_doe === 0, "R7 released", ser_doe, 0);
    vis_word = 16'h8001;
    send_code(4'b0001);
    vis_word = 16'h0000;
    read_vis(v);
    check(v === 16'h8001, "R6 captured at code end", v, 16'h8001);

    // R8: unknown codes
    send_code(4'b0110);
    check(insn_valid === 0 && ser_doe === 0, "R8 code 6 ignored", {insn_valid, ser_doe}, 0);
    send_code(4'b1111);
    check(insn_valid === 0 && ser_doe === 0, "R8 code 15 ignored", {insn_valid, ser_doe}, 0);
    send_code(4'b0000); send_word(24'h00FF00);
    check(insn_valid === 1 && insn_data === 24'h00FF00, "R8 next code decoded", insn_data, 24'h00FF00);

    // R5: completion on the accepting edge
    send_code(4'b0000);
    for (int i = 0; i < 23; i++) bit_out(1'b0);
    ser_din = 1'b1;
    ser_clk = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    insn_ready = 1'b1;
    @(negedge clk);
    insn_ready = 1'b0;
    check(insn_valid === 1 && insn_data === 24'h800000, "R5 same-edge accept and complete",
          insn_data, 24'h800000);
    repeat (4) @(negedge clk);
    accept();
    check(insn_valid === 0, "R5 cleared", insn_valid, 0);

    // R1: leave with a pending word, then re-enter (R9 forced frame again)
    send_code(4'b0000); send_word(24'h0F0F0F);
    hv_reset = 1'b0;
    repeat (3) @(negedge clk);
    check(prog_active === 0 && insn_valid === 0 && ser_doe === 0, "R1 disarm clears",
          {prog_active, insn_valid, ser_doe}, 0);
    hv_reset = 1'b1;
    repeat (3) @(negedge clk);
    send_pad(); send_word(24'h5A5A5A);
    check(insn_valid === 1 && insn_data === 24'h5A5A5A, "R9 re-armed forced word", insn_data, 24'h5A5A5A);
    accept();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule